// File: doc/BRIEF.md
# Skid-Buffered Decode Stage

This block is one in-order pipeline stage for a single instruction stream. It sits between an upstream fetch stage and a downstream rename stage. Every cycle up to `IN_W` tokens arrive from upstream, and up to `DEC_W` tokens are forwarded downstream on registered outputs. Each token carries a sequence number, a squashed mark, a direct-unconditional-branch mark, the target computed for it and the target that was predicted for it.

When the downstream stage stalls, or when more tokens arrive than can be forwarded, the stage parks the surplus in a circular skid buffer of `(UP_LAT + 1) * IN_W` entries. It tells upstream to stop with a one-cycle block message and later to resume with a one-cycle unblock message. If a block and an unblock would both be produced in the same cycle, the two cancel. The buffer is drained oldest-first before fresh work is taken again. A squash from the commit side flushes all held work. A direct unconditional branch whose computed target differs from its prediction raises a redirect upstream, stops issue after the branch and flushes the younger work.

Top module: `decode_skid_stage`

## Requirements
- R1: After reset every output is 0 and the skid buffer is empty, so the first tokens offered afterwards are forwarded directly.
- R2: Input lanes are valid contiguously from lane 0. When not stalled and with the buffer empty, up to `DEC_W` tokens are forwarded in lane order on the outputs one cycle after they are offered. Slot k of `out_seq` occupies bits `[k*SEQ_W +: SEQ_W]`, and an unused slot reads 0.
- R3: A token offered with `in_squashed` = 1 is dropped and uses no output slot. The next token takes its slot.
- R4: When more live tokens are present than free output slots, the surplus goes into the skid buffer, `up_block` pulses for one cycle and the stage enters the blocked state.
- R5: A `ren_block` pulse sets a held stall flag and a `ren_unblock` pulse clears it. While the flag is set nothing is forwarded and all inputs are parked. `up_block` pulses only on entry to the blocked state. An unblock pulse with no stall recorded is a protocol error.
- R6: When the stall clears, the stage forwards from the skid buffer oldest-first, up to `DEC_W` per cycle, and appends new arrivals behind the held tokens. In the cycle the buffer becomes empty, `up_unblock` pulses and live forwarding resumes.
- R7: If leaving the blocked state with an empty buffer produces an unblock while a surplus of live tokens forces a new block in the same cycle, the pending unblock is withdrawn and neither message is sent. `up_block` and `up_unblock` are never high together.
- R8: `commit_squash` takes priority over any stall. In that cycle nothing is forwarded, the buffer and the inputs are discarded, and `up_unblock` pulses if the stage was blocked or unblocking.
- R9: The squashing state lasts one cycle. The next cycle forwards live tokens, unless a stall is recorded, in which case the stage blocks and pulses `up_block`.
- R10: A forwarded token with its direct-unconditional mark set and a computed target different from its predicted target raises `redir_valid` with its sequence number, its computed target and `redir_taken` = 1. Later tokens that cycle are not forwarded, and the buffer is flushed.
- R11: A push beyond the buffer capacity is not stored, and `skid_overflow` pulses for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | IN_W | Per-lane valid, contiguous from lane 0 |
| in_seq | input | IN_W*SEQ_W | Per-lane sequence number |
| in_squashed | input | IN_W | Per-lane squashed mark |
| in_dir_uncond | input | IN_W | Per-lane direct unconditional branch mark |
| in_target | input | IN_W*TGT_W | Per-lane computed target |
| in_pred_target | input | IN_W*TGT_W | Per-lane predicted target |
| ren_block | input | 1 | Downstream stall pulse |
| ren_unblock | input | 1 | Downstream resume pulse |
| commit_squash | input | 1 | Squash request from the commit side |
| out_valid | output | DEC_W | Per-slot forwarded valid |
| out_seq | output | DEC_W*SEQ_W | Per-slot forwarded sequence number |
| up_block | output | 1 | Block message to upstream |
| up_unblock | output | 1 | Unblock message to upstream |
| redir_valid | output | 1 | Branch redirect to upstream |
| redir_seq | output | SEQ_W | Sequence number of the mispredicted branch |
| redir_target | output | TGT_W | Corrected target |
| redir_taken | output | 1 | Taken indication of the redirect |
| skid_overflow | output | 1 | Skid buffer push beyond capacity |

## Verification
Two of the stage's functions can fall in the same cycle. The first is leaving the blocked state with an empty buffer, which raises an unblock. The second is a live surplus, which raises a block. The bench provokes this by stalling with no tokens in flight and then releasing the stall together with three tokens against two output slots. It expects the first two tokens forwarded, the third held back, and both `up_block` and `up_unblock` low, with the unblock arriving only when the held token leaves. A second collision applies `commit_squash` and `ren_block` together. The bench expects no block message in that cycle and a block exactly one cycle later.

// File: rtl/decode_skid_stage.sv
module decode_skid_stage #(
  parameter int IN_W   = 3,
  parameter int DEC_W  = 2,
  parameter int UP_LAT = 1,
  parameter int SEQ_W  = 8,
  parameter int TGT_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [IN_W-1:0]        in_valid,
  input  logic [IN_W*SEQ_W-1:0]  in_seq,
  input  logic [IN_W-1:0]        in_squashed,
  input  logic [IN_W-1:0]        in_dir_uncond,
  input  logic [IN_W*TGT_W-1:0]  in_target,
  input  logic [IN_W*TGT_W-1:0]  in_pred_target,
  input  logic                   ren_block,
  input  logic                   ren_unblock,
  input  logic                   commit_squash,
  output logic [DEC_W-1:0]       out_valid,
  output logic [DEC_W*SEQ_W-1:0] out_seq,
  output logic                   up_block,
  output logic                   up_unblock,
  output logic                   redir_valid,
  output logic [SEQ_W-1:0]       redir_seq,
  output logic [TGT_W-1:0]       redir_target,
  output logic                   redir_taken,
  output logic                   skid_overflow
);
  localparam int DEPTH = (UP_LAT + 1) * IN_W;
  localparam int PW    = DEPTH > 1 ? $clog2(DEPTH) : 1;
  localparam int CW    = $clog2(DEPTH + 1);
  localparam int SRC_N = DEPTH > IN_W ? DEPTH : IN_W;

  typedef enum logic [2:0] {ST_IDLE, ST_RUN, ST_BLK, ST_UNBLK, ST_SQ} st_t;
  typedef struct packed {
    logic [SEQ_W-1:0] seq;
    logic             sq;
    logic             dir;
    logic [TGT_W-1:0] tgt;
    logic [TGT_W-1:0] ptgt;
  } tok_t;

  st_t st_q, st_n;
  logic stall_q, stall_n;
  tok_t skid_q [DEPTH];
  logic [PW-1:0] head_q, head_n;
  logic [CW-1:0] cnt_q, cnt_n;

  tok_t live [IN_W];
  tok_t src  [SRC_N];
  int   live_n, avail, used, slots, pop_n, push_lo, pushed;
  logic stop, from_skid, flush;
  logic [IN_W-1:0]  push_en;
  logic [PW-1:0]    push_idx [IN_W];

  logic [DEC_W-1:0]       nx_ov;
  logic [DEC_W*SEQ_W-1:0] nx_seq;
  logic                   nx_blk, nx_unb, nx_rv, nx_ovf;
  logic [SEQ_W-1:0]       nx_rs;
  logic [TGT_W-1:0]       nx_rt;

  assign live_n = $countones(in_valid);

  always_comb begin
    for (int i = 0; i < IN_W; i++)
      live[i] = '{seq: in_seq[i*SEQ_W +: SEQ_W], sq: in_squashed[i], dir: in_dir_uncond[i],
                  tgt: in_target[i*TGT_W +: TGT_W], ptgt: in_pred_target[i*TGT_W +: TGT_W]};
  end

  always_comb begin
    stall_n = (stall_q | ren_block) & ~ren_unblock;
    st_n = st_q;
    nx_ov = '0; nx_seq = '0; nx_blk = 1'b0; nx_unb = 1'b0;
    nx_rv = 1'b0; nx_rs = '0; nx_rt = '0;
    flush = 1'b0; pop_n = 0; push_lo = IN_W; used = 0; slots = 0;
    stop = 1'b0; from_skid = 1'b0; avail = 0;
    for (int i = 0; i < SRC_N; i++) src[i] = '0;

    if (commit_squash) begin
      if (st_q == ST_BLK || st_q == ST_UNBLK) nx_unb = 1'b1;
      st_n  = ST_SQ;
      flush = 1'b1;
    end else if (stall_n) begin
      push_lo = 0;
      if (st_q != ST_BLK) begin
        st_n   = ST_BLK;
        nx_blk = 1'b1;
      end
    end else begin
      if (st_q == ST_BLK) begin
        if (cnt_q == '0) begin
          nx_unb = 1'b1;
          st_n   = ST_RUN;
        end else begin
          st_n = ST_UNBLK;
        end
      end else if (st_q == ST_SQ) begin
        st_n = ST_RUN;
      end

      from_skid = (st_n == ST_UNBLK);
      if (from_skid) begin
        avail = int'(cnt_q);
        for (int i = 0; i < DEPTH; i++) src[i] = skid_q[PW'((int'(head_q) + i) % DEPTH)];
      end else begin
        avail = live_n;
        for (int i = 0; i < IN_W; i++) src[i] = live[i];
      end

      for (int i = 0; i < SRC_N; i++) begin
        if (i < avail && !stop) begin
          if (src[i].sq) begin
            used = i + 1;
          end else if (slots < DEC_W) begin
            for (int s = 0; s < DEC_W; s++)
              if (s == slots) begin
                nx_ov[s] = 1'b1;
                nx_seq[s*SEQ_W +: SEQ_W] = src[i].seq;
              end
            slots = slots + 1;
            used  = i + 1;
            if (src[i].dir && src[i].tgt != src[i].ptgt) begin
              nx_rv = 1'b1;
              nx_rs = src[i].seq;
              nx_rt = src[i].tgt;
              stop  = 1'b1;
            end
          end else begin
            stop = 1'b1;
          end
        end
      end

      if (nx_rv) begin
        flush = 1'b1;
        st_n  = ST_SQ;
        if (from_skid) nx_unb = 1'b1;
      end else if (from_skid) begin
        pop_n   = used;
        push_lo = 0;
        if (avail - used + live_n == 0) begin
          nx_unb = 1'b1;
          st_n   = ST_RUN;
        end
      end else if (used < live_n) begin
        push_lo = used;
        st_n    = ST_BLK;
        if (nx_unb) nx_unb = 1'b0;
        else        nx_blk = 1'b1;
      end else if (used > 0) begin
        st_n = ST_RUN;
      end
    end

    pushed = 0;
    nx_ovf = 1'b0;
    for (int k = 0; k < IN_W; k++) begin
      push_en[k]  = 1'b0;
      push_idx[k] = '0;
      if (!flush && k >= push_lo && k < live_n) begin
        if (int'(cnt_q) - pop_n + pushed < DEPTH) begin
          push_en[k]  = 1'b1;
          push_idx[k] = PW'((int'(head_q) + int'(cnt_q) + pushed) % DEPTH);
          pushed      = pushed + 1;
        end else begin
          nx_ovf = 1'b1;
        end
      end
    end
    cnt_n  = flush ? '0 : CW'(int'(cnt_q) - pop_n + pushed);
    head_n = flush ? '0 : PW'((int'(head_q) + pop_n) % DEPTH);
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < IN_W; k++)
      if (push_en[k]) skid_q[push_idx[k]] <= live[k];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      stall_q <= 1'b0;
      head_q <= '0;
      cnt_q <= '0;
      out_valid <= '0;
      out_seq <= '0;
      up_block <= 1'b0;
      up_unblock <= 1'b0;
      redir_valid <= 1'b0;
      redir_seq <= '0;
      redir_target <= '0;
      redir_taken <= 1'b0;
      skid_overflow <= 1'b0;
    end else begin
      st_q <= st_n;
      stall_q <= stall_n;
      head_q <= head_n;
      cnt_q <= cnt_n;
      out_valid <= nx_ov;
      out_seq <= nx_seq;
      up_block <= nx_blk;
      up_unblock <= nx_unb;
      redir_valid <= nx_rv;
      redir_seq <= nx_rs;
      redir_target <= nx_rt;
      redir_taken <= nx_rv;
      skid_overflow <= nx_ovf;
    end
  end

  // R5
  stall_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stall_n |=> out_valid == '0);

  // R5
  unblock_proto_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ren_unblock |-> (stall_q || ren_block));

  // R7
  handshake_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(up_block && up_unblock));

  // R8
  squash_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    commit_squash |=> (out_valid == '0 && !redir_valid));

  // R10
  redirect_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    redir_valid |-> cnt_q == '0);

  // R11
  skid_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));
endmodule

// File: tb/sim_decode_skid_stage.sv
module sim_decode_skid_stage;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0]  in_valid = '0;
  logic [23:0] in_seq = '0;
  logic [2:0]  in_squashed = '0;
  logic [2:0]  in_dir_uncond = '0;
  logic [47:0] in_target = '0;
  logic [47:0] in_pred_target = '0;
  logic ren_block = 1'b0, ren_unblock = 1'b0, commit_squash = 1'b0;
  logic [1:0]  out_valid;
  logic [15:0] out_seq;
  logic up_block, up_unblock, redir_valid, redir_taken, skid_overflow;
  logic [7:0]  redir_seq;
  logic [15:0] redir_target;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  decode_skid_stage u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_seq(in_seq),
    .in_squashed(in_squashed), .in_dir_uncond(in_dir_uncond),
    .in_target(in_target), .in_pred_target(in_pred_target),
    .ren_block(ren_block), .ren_unblock(ren_unblock), .commit_squash(commit_squash),
    .out_valid(out_valid), .out_seq(out_seq), .up_block(up_block), .up_unblock(up_unblock),
    .redir_valid(redir_valid), .redir_seq(redir_seq), .redir_target(redir_target),
    .redir_taken(redir_taken), .skid_overflow(skid_overflow)
  );

  typedef struct packed {
    logic [2:0] v;
    logic [7:0] base;
    logic [2:0] sq;
    logic       rb, ru, cs;
    logic [1:0] eov;
    logic [7:0] es0, es1;
    logic       eblk, eunb;
    logic [7:0] req;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VECS [NV] = '{
    '{3'b111, 8'd10,  3'b000, 1'b0, 1'b0, 1'b0, 2'b11, 8'd10,  8'd11,  1'b1, 1'b0, 8'd4},  // R4
    '{3'b000, 8'd0,   3'b000, 1'b0, 1'b0, 1'b0, 2'b01, 8'd12,  8'd0,   1'b0, 1'b1, 8'd6},  // R6
    '{3'b011, 8'd20,  3'b000, 1'b0, 1'b0, 1'b0, 2'b11, 8'd20,  8'd21,  1'b0, 1'b0, 8'd2},  // R2
    '{3'b111, 8'd30,  3'b010, 1'b0, 1'b0, 1'b0, 2'b11, 8'd30,  8'd32,  1'b0, 1'b0, 8'd3},  // R3
    '{3'b011, 8'd40,  3'b000, 1'b1, 1'b0, 1'b0, 2'b00, 8'd0,   8'd0,   1'b1, 1'b0, 8'd5},  // R5
    '{3'b001, 8'd50,  3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 8'd0,   8'd0,   1'b0, 1'b0, 8'd5},  // R5
    '{3'b000, 8'd0,   3'b000, 1'b0, 1'b1, 1'b0, 2'b11, 8'd40,  8'd41,  1'b0, 1'b0, 8'd6},  // R6
    '{3'b011, 8'd60,  3'b000, 1'b0, 1'b0, 1'b0, 2'b01, 8'd50,  8'd0,   1'b0, 1'b0, 8'd6},  // R6
    '{3'b000, 8'd0,   3'b000, 1'b0, 1'b0, 1'b0, 2'b11, 8'd60,  8'd61,  1'b0, 1'b1, 8'd6},  // R6
    '{3'b000, 8'd0,   3'b000, 1'b1, 1'b0, 1'b0, 2'b00, 8'd0,   8'd0,   1'b1, 1'b0, 8'd5},  // R5
    '{3'b111, 8'd70,  3'b000, 1'b0, 1'b1, 1'b0, 2'b11, 8'd70,  8'd71,  1'b0, 1'b0, 8'd7},  // R7
    '{3'b000, 8'd0,   3'b000, 1'b0, 1'b0, 1'b0, 2'b01, 8'd72,  8'd0,   1'b0, 1'b1, 8'd6},  // R6
    '{3'b011, 8'd80,  3'b000, 1'b1, 1'b0, 1'b0, 2'b00, 8'd0,   8'd0,   1'b1, 1'b0, 8'd5},  // R5
    '{3'b001, 8'd90,  3'b000, 1'b0, 1'b1, 1'b1, 2'b00, 8'd0,   8'd0,   1'b0, 1'b1, 8'd8},  // R8
    '{3'b011, 8'd160, 3'b000, 1'b0, 1'b0, 1'b0, 2'b11, 8'd160, 8'd161, 1'b0, 1'b0, 8'd9},  // R9
    '{3'b011, 8'd170, 3'b000, 1'b0, 1'b0, 1'b1, 2'b00, 8'd0,   8'd0,   1'b0, 1'b0, 8'd8},  // R8
    '{3'b001, 8'd180, 3'b000, 1'b0, 1'b0, 1'b0, 2'b01, 8'd180, 8'd0,   1'b0, 1'b0, 8'd9},  // R9
    '{3'b011, 8'd190, 3'b000, 1'b1, 1'b0, 1'b1, 2'b00, 8'd0,   8'd0,   1'b0, 1'b0, 8'd8},  // R8
    '{3'b001, 8'd200, 3'b000, 1'b0, 1'b0, 1'b0, 2'b00, 8'd0,   8'd0,   1'b1, 1'b0, 8'd9},  // R9
    '{3'b000, 8'd0,   3'b000, 1'b0, 1'b1, 1'b0, 2'b01, 8'd200, 8'd0,   1'b0, 1'b1, 8'd6}   // R6
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [2:0] v, input logic [7:0] base, input logic [2:0] sq,
                       input logic rb, input logic ru, input logic cs);
    in_valid = v;
    for (int i = 0; i < 3; i++) in_seq[i*8 +: 8] = base + 8'(i);
    in_squashed = sq;
    in_dir_uncond = '0;
    in_target = '0;
    in_pred_target = '0;
    ren_block = rb;
    ren_unblock = ru;
    commit_squash = cs;
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [63:0] outs();
    return {out_valid, out_seq, up_block, up_unblock, redir_valid, skid_overflow};
  endfunction

  function automatic logic [63:0] expv(input logic [1:0] ov, input logic [7:0] s0, input logic [7:0] s1,
                                       input logic blk, input logic unb, input logic rv, input logic ovf);
    return {ov, s1, s0, blk, unb, rv, ovf};
  endfunction

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin
    drive(3'b000, 8'd0, 3'b000, 1'b0, 1'b0, 1'b0);
    repeat (2) @(posedge clk);
    #1;
    // R1: outputs quiet in reset and right after release
    chk("R1", {outs(), redir_seq, redir_target, redir_taken}, '0);
    rst_n = 1'b1;
    step();
    chk("R1", outs(), '0);

    for (int n = 0; n < NV; n++) begin
      drive(VECS[n].v, VECS[n].base, VECS[n].sq, VECS[n].rb, VECS[n].ru, VECS[n].cs);
      step();
      chk($sformatf("R%0d row %0d", VECS[n].req, n), outs(),
          expv(VECS[n].eov, VECS[n].es0, VECS[n].es1, VECS[n].eblk, VECS[n].eunb, 1'b0, 1'b0));
    end

    // R11: fill six entries, then a third batch overflows
    drive(3'b111, 8'd210, 3'b000, 1'b1, 1'b0, 1'b0); step();
    chk("R11 fill1", outs(), expv(2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    drive(3'b111, 8'd220, 3'b000, 1'b0, 1'b0, 1'b0); step();
    chk("R11 fill2", outs(), expv(2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    drive(3'b111, 8'd230, 3'b000, 1'b0, 1'b0, 1'b0); step();
    chk("R11 overflow", outs(), expv(2'b00, 8'd0, 8'd0, 1'b0, 1'b0, 1'b0, 1'b1));
    drive(3'b000, 8'd0, 3'b000, 1'b0, 1'b1, 1'b0); step();
    chk("R6 drain1", outs(), expv(2'b11, 8'd210, 8'd211, 1'b0, 1'b0, 1'b0, 1'b0));
    drive(3'b000, 8'd0, 3'b000, 1'b0, 1'b0, 1'b0); step();
    chk("R6 drain2", outs(), expv(2'b11, 8'd212, 8'd220, 1'b0, 1'b0, 1'b0, 1'b0));
    step();
    chk("R11 drain3", outs(), expv(2'b11, 8'd221, 8'd222, 1'b0, 1'b1, 1'b0, 1'b0));
    step();
    chk("R11 dropped batch absent", outs(), '0);

    // R1: reset while blocked discards held tokens
    drive(3'b011, 8'd240, 3'b000, 1'b1, 1'b0, 1'b0); step();
    chk("R5 block before reset", outs(), expv(2'b00, 8'd0, 8'd0, 1'b1, 1'b0, 1'b0, 1'b0));
    drive(3'b000, 8'd0, 3'b000, 1'b0, 1'b0, 1'b0);
    rst_n = 1'b0;
    step();
    chk("R1 mid reset", outs(), '0);
    rst_n = 1'b1;
    drive(3'b001, 8'd250, 3'b000, 1'b0, 1'b0, 1'b0); step();
    chk("R1 after reset", outs(), expv(2'b01, 8'd250, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0));

    // R10: lane 1 is a mispredicted direct branch
    drive(3'b111, 8'd1, 3'b000, 1'b0, 1'b0, 1'b0);
    in_dir_uncond = 3'b010;
    in_target[16 +: 16] = 16'h0055;
    in_pred_target[16 +: 16] = 16'h0044;
    step();
    chk("R10 issue", outs(), expv(2'b11, 8'd1, 8'd2, 1'b0, 1'b0, 1'b1, 1'b0));
    chk("R10 redirect", {redir_seq, redir_target, redir_taken}, {8'd2, 16'h0055, 1'b1});
    drive(3'b001, 8'd9, 3'b000, 1'b0, 1'b0, 1'b0); step();
    chk("R9 after redirect", outs(), expv(2'b01, 8'd9, 8'd0, 1'b0, 1'b0, 1'b0, 1'b0));
    drive(3'b011, 8'd10, 3'b000, 1'b0, 1'b0, 1'b0);
    in_dir_uncond = 3'b001;
    in_target[0 +: 16] = 16'h0033;
    in_pred_target[0 +: 16] = 16'h0033;
    step();
    chk("R10 correct branch", outs(), expv(2'b11, 8'd10, 8'd11, 1'b0, 1'b0, 1'b0, 1'b0));

    done = 1'b1;
    finish_run();
  end
endmodule